// File: doc/BRIEF.md
# Watchdog and Interval Timer with Set-Only Control

This block is a free-running up-counter with two uses. As an interval timer it raises a one-cycle interrupt request each time the count wraps. As a watchdog it raises a one-cycle fault request on overflow and latches a fault flag that stays up until reset. Software must keep clearing the count to stop a watchdog overflow.

Software drives the block through an 8-bit control register. A write can cover the whole byte, or it can name one bit position and give that bit a value. Two bits of the register matter. The start bit, at position 7, clears the count and starts counting. The watchdog-select bit, at position 4, chooses the mode. Both bits can be set but never cleared. Once software has started the timer or armed the watchdog, only a reset can undo it. Each fresh write of 1 to the start bit clears the count again, and this is how software services the watchdog.

The count width and the terminal count are parameters. The block counts on every clock. The clock is assumed to be prescaled already.

Top module: `wdt_timer`

## Requirements
- R1: After reset, `rd_data` is 0x00, `count_o` is 0 and `irq_o`, `fault_o` and `fault_flag_o` are all low.
- R2: `rd_data` shows the start bit at position 7 and the watchdog-select bit at position 4. Every other position always reads 0, whatever was written.
- R3: A write that carries a 1 to the start bit makes `count_o` 0 on the next edge. A byte write does this with `wr_data[7]`=1. A single-bit write does it with `wr_idx`=7 and `wr_data[0]`=1. After that, the count rises by one on each clock.
- R4: While the start bit is 0, `count_o` holds its value.
- R5: In interval mode (watchdog-select 0), a running count that is at TERMINAL on an edge goes to 0 on that edge. `irq_o` is high for exactly the following cycle, and counting continues.
- R6: In watchdog mode (watchdog-select 1), the same overflow gives a one-cycle `fault_o` pulse instead of `irq_o`. `fault_flag_o` rises together with the pulse and stays high until reset.
- R7: No write clears the start bit or the watchdog-select bit, whether it is a byte write or a single-bit write. A write of 0 to these bits leaves the count unaffected.
- R8: Writing 1 to the start bit while the timer runs restarts the count from 0. If the restart falls on an overflow edge, it wins and no request is raised.
- R9: A single-bit write with `wr_idx`=4 and `wr_data[0]`=1 selects watchdog mode. Single-bit writes to any position other than 7 or 4 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, already prescaled |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_single | input | 1 | 1: single-bit write, 0: byte write |
| wr_idx | input | 3 | Bit position for a single-bit write |
| wr_data | input | 8 | Byte data; bit 0 is the value for a single-bit write |
| rd_data | output | 8 | Control register readback |
| count_o | output | CNT_W | Current count |
| irq_o | output | 1 | Interval interrupt request pulse |
| fault_o | output | 1 | Watchdog fault request pulse |
| fault_flag_o | output | 1 | Sticky watchdog fault flag |

## Verification
Every result is due one edge after its cause. A write shows in `rd_data` and `count_o` after the edge that samples it. An overflow shows as a request in the cycle after the count stood at TERMINAL. The bench drives inputs just after a falling edge and updates a behavioural model on the rising edge, using the same inputs the design saw. It compares every output with the model at the next falling edge, so each comparison lands in the cycle the result is due. Directed checks after each phase confirm the request counts and the register readback.

// File: rtl/wdt_timer.sv
module wdt_timer #(
  parameter int CNT_W    = 16,
  parameter int TERMINAL = 65535
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_single,
  input  logic [2:0]       wr_idx,
  input  logic [7:0]       wr_data,
  output logic [7:0]       rd_data,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_o,
  output logic             fault_o,
  output logic             fault_flag_o
);
  localparam logic [CNT_W-1:0] TERM_V = CNT_W'(TERMINAL);

  logic run_q, wdog_q;
  logic set_run, set_wdog, at_term, ovf;

  assign set_run  = wr_en && (wr_single ? (wr_idx == 3'd7 && wr_data[0]) : wr_data[7]);
  assign set_wdog = wr_en && (wr_single ? (wr_idx == 3'd4 && wr_data[0]) : wr_data[4]);
  assign at_term  = (count_o == TERM_V);
  assign ovf      = run_q && at_term && !set_run;
  assign rd_data  = {run_q, 2'b00, wdog_q, 4'b0000};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      wdog_q <= 1'b0;
    end else begin
      run_q  <= run_q | set_run;
      wdog_q <= wdog_q | set_wdog;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         count_o <= '0;
    else if (set_run)   count_o <= '0;
    else if (run_q)     count_o <= at_term ? '0 : count_o + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o        <= 1'b0;
      fault_o      <= 1'b0;
      fault_flag_o <= 1'b0;
    end else begin
      irq_o        <= ovf && !wdog_q;
      fault_o      <= ovf && wdog_q;
      fault_flag_o <= fault_flag_o | (ovf && wdog_q);
    end
  end
endmodule

module wdt_timer_chk #(
  parameter int CNT_W    = 16,
  parameter int TERMINAL = 65535
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [7:0]       rd_data,
  input logic [CNT_W-1:0] count_o,
  input logic             irq_o,
  input logic             fault_o,
  input logic             fault_flag_o
);
  initial a_r5_term_fits: assert (TERMINAL >= 1 && TERMINAL < (2 ** CNT_W));

  a_r7_run_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7] |=> rd_data[7]);
  a_r7_wdog_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[4] |=> rd_data[4]);
  a_r2_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & 8'h6F) == 8'h00);
  a_r4_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data[7] && !wr_en) |=> $stable(count_o));
  a_r5_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);
  a_r6_no_irq_in_wdog: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[4] |=> !irq_o);
  a_r6_fault_single: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |=> !fault_o);
  a_r6_flag_with_fault: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> fault_flag_o);
  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fault_flag_o |=> fault_flag_o);
endmodule

bind wdt_timer wdt_timer_chk #(.CNT_W(CNT_W), .TERMINAL(TERMINAL)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_data(rd_data), .count_o(count_o),
  .irq_o(irq_o), .fault_o(fault_o), .fault_flag_o(fault_flag_o)
);

// File: tb/test_wdt_timer.sv
module test_wdt_timer;
  localparam int W = 4;
  localparam int TERM = 9;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, wr_single = 1'b0;
  logic [2:0] wr_idx = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [W-1:0] count_o;
  logic irq_o, fault_o, fault_flag_o;

  wdt_timer #(.CNT_W(W), .TERMINAL(TERM)) i_wdt_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_single(wr_single), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_data(rd_data), .count_o(count_o), .irq_o(irq_o),
    .fault_o(fault_o), .fault_flag_o(fault_flag_o));

  always #5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, irqs = 0, faults = 0;
  bit m_run, m_wd, m_irq, m_fault, m_flag;
  int m_cnt;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_wd = 0; m_irq = 0; m_fault = 0; m_flag = 0; m_cnt = 0;
    end else begin
      bit srun, swd, ov;
      srun = wr_en && (wr_single ? (wr_idx == 7 && wr_data[0]) : wr_data[7]);
      swd  = wr_en && (wr_single ? (wr_idx == 4 && wr_data[0]) : wr_data[4]);
      ov = m_run && !srun && m_cnt == TERM;
      m_irq = ov && !m_wd;
      m_fault = ov && m_wd;
      if (m_fault) m_flag = 1;
      if (srun) m_cnt = 0;
      else if (m_run) m_cnt = (m_cnt == TERM) ? 0 : m_cnt + 1;
      if (srun) m_run = 1;
      if (swd) m_wd = 1;
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk("R2 R7 readback", rd_data, {m_run, 2'b00, m_wd, 4'b0000});
    chk("R3 R4 R8 count", count_o, m_cnt);
    chk("R5 irq", irq_o, m_irq);
    chk("R6 fault", fault_o, m_fault);
    chk("R6 flag", fault_flag_o, m_flag);
    if (irq_o) irqs++;
    if (fault_o) faults++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wbyte(logic [7:0] d);
    @(negedge clk); #1;
    wr_en = 1; wr_single = 0; wr_data = d;
    @(negedge clk); #1;
    wr_en = 0; wr_data = 0;
  endtask

  task automatic wbit(logic [2:0] i, logic v);
    @(negedge clk); #1;
    wr_en = 1; wr_single = 1; wr_idx = i; wr_data = {7'b0, v};
    @(negedge clk); #1;
    wr_en = 0; wr_single = 0; wr_idx = 0; wr_data = 0;
  endtask

  initial begin
    idle(2); #1; rst_n = 1;
    idle(1);
    chk("R1 reset rd", rd_data, 0);
    chk("R1 reset count", count_o, 0);
    chk("R1 reset outs", {irq_o, fault_o, fault_flag_o}, 0);
    idle(5);
    chk("R4 stopped count", count_o, 0);
    wbit(3'd5, 1'b1); wbit(3'd0, 1'b1); wbit(3'd7, 1'b0);
    chk("R9 other bits ignored", rd_data, 0);
    wbyte(8'h80);
    chk("R3 started", rd_data, 8'h80);
    idle(25);
    chk("R5 irq pulses", int'(irqs >= 2), 1);
    wbyte(8'h00); wbit(3'd7, 1'b0); wbit(3'd4, 1'b0);
    chk("R7 clear ignored", rd_data, 8'h80);
    idle(3);
    irqs = 0;
    for (int k = 0; k < 8; k++) begin wbyte(8'h80); idle(4); end
    chk("R8 serviced no irq", irqs, 0);
    wbit(3'd4, 1'b1);
    chk("R9 bit write sets mode", rd_data, 8'h90);
    idle(25);
    chk("R6 fault seen", int'(faults >= 1), 1);
    chk("R6 flag set", fault_flag_o, 1);
    chk("R6 no irq in wdog", irqs, 0);
    wbyte(8'h6F); wbit(3'd7, 1'b0);
    chk("R2 R7 held", rd_data, 8'h90);
    chk("R6 flag held", fault_flag_o, 1);
    @(negedge clk); #1; rst_n = 0;
    idle(2); #1; rst_n = 1;
    idle(1);
    chk("R1 R6 reset clears flag", fault_flag_o, 0);
    chk("R1 reset clears rd", rd_data, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule